// File: doc/BRIEF.md
# Framed PRBS Pattern Lock Monitor

This block watches a recovered T1 or E1 serial stream, one bit per enable strobe, and reports whether the payload carries one of two pseudorandom test patterns. One pattern is a 2^15−1 sequence. The other is a quasi-random 2^20−1 sequence with zero suppression. Each pattern has its own detector and its own lock flag. The detectors run side by side and do not affect each other.

An external framer supplies a strobe that marks the first bit of each frame. From it the block tracks the bit position. It skips the framing bit of a DS1 frame and time slot 0 of a CEPT frame, so only payload bits reach the detectors. A detector first loads received bits into its shift register to seed itself. It then predicts each following bit and compares it with the received bit. It declares lock after 256 error-free comparisons in a row. Once locked, it runs on its own and drops lock only when one frame holds more than 32 errors. The payload must be free of signaling: the block does not compensate for robbed bits or time slot 16.

Top module: `prbs_lock_monitor`

## Requirements
- R1: While reset is low, and directly after reset, both lock flags are 0.
- R2: In DS1 mode (mode_cept = 0) a frame has 193 bit positions. A strobed bit with frame_start high is position 0. Otherwise the position advances by one and wraps from 192 to 0. Position 0 is never compared.
- R3: In CEPT mode (mode_cept = 1) a frame has 256 positions, counted the same way. Positions 0 to 7 are never compared.
- R4: A clock cycle with bit_en low changes neither the bit position, nor any detector state, nor the lock flags, whatever rx_bit is.
- R5: While searching, a detector loads its first L compared bits (L = 15 or 20) as its seed. If the seed is all zeros it is rejected, and seeding starts again.
- R6: After a valid seed, 256 compared bits in a row that match the prediction raise the lock flag one clock after the 256th bit. On a clean 2^15−1 stream, lock_p15 is therefore high after the 271st payload bit.
- R7: A mismatch during the 256-bit run throws away that bit. Seeding restarts with the next compared bit.
- R8: While locked, the error count restarts at the first payload bit of each frame. A frame with 32 or fewer errors keeps the flag high.
- R9: The 33rd error in one frame clears the flag one clock after that bit, and the detector goes back to seeding.
- R10: The 2^15−1 raw sequence follows s[n] = s[n−14] XOR s[n−15]. The transmitted bit equals s[n].
- R11: The quasi-random raw sequence follows s[n] = s[n−17] XOR s[n−20]. The transmitted bit is forced to 1 when the 14 raw bits before it are all zero, and equals s[n] otherwise.
- R12: Each flag responds only to its own pattern. A stream of one pattern never raises the other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies rx_bit as one received line bit |
| rx_bit | input | 1 | Received serial data bit |
| frame_start | input | 1 | With bit_en, marks the current bit as frame position 0 |
| mode_cept | input | 1 | 0: 193-bit DS1 frame, 1: 256-bit CEPT frame |
| lock_p15 | output | 1 | Locked to the 2^15−1 pattern |
| lock_qrs | output | 1 | Locked to the quasi-random 2^20−1 pattern |

## Verification
Every flag change is due exactly one clock after the strobed bit that causes it: the 256th clean comparison for lock, the 33rd error of a frame for loss. Cycles without a strobe leave the flags unchanged. The bench steps its behavioural model at the same rising edge the design uses and compares both flags at every falling edge, so each result is checked in the cycle it becomes due. Directed checks count payload bits to pin lock onset at bit 271, and at bit 372 after a mismatch at bit 101. They also check the flags at frame ends after 32-error and 33-error frames, after an all-zero payload, and with the other pattern on the line.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  typedef enum logic [1:0] {
    DET_SEED  = 2'd0,
    DET_TRACK = 2'd1,
    DET_LOCK  = 2'd2
  } det_state_e;

  // Raw next bit of an LFSR whose history has the newest bit at index 0.
  function automatic logic lfsr_feedback(input logic [31:0] hist, input int tap, input int len);
    return hist[tap-1] ^ hist[len-1];
  endfunction

  // True when the newest n history bits are all zero.
  function automatic logic zero_window(input logic [31:0] hist, input int n);
    return (hist & ((32'd1 << n) - 32'd1)) == 32'd0;
  endfunction

endpackage

// File: rtl/frame_tracker.sv
module frame_tracker #(
  parameter int DS1_LEN  = 193,
  parameter int DS1_HDR  = 1,
  parameter int CEPT_LEN = 256,
  parameter int CEPT_HDR = 8,
  parameter int POS_W    = $clog2((DS1_LEN > CEPT_LEN) ? DS1_LEN : CEPT_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic frame_start,
  input  logic mode_cept,
  output logic cmp_en,
  output logic first_payload
);

  localparam logic [POS_W-1:0] DS1_LAST  = POS_W'(DS1_LEN - 1);
  localparam logic [POS_W-1:0] CEPT_LAST = POS_W'(CEPT_LEN - 1);
  localparam logic [POS_W-1:0] DS1_H     = POS_W'(DS1_HDR);
  localparam logic [POS_W-1:0] CEPT_H    = POS_W'(CEPT_HDR);

  logic [POS_W-1:0] last_pos;
  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] frame_last;
  logic [POS_W-1:0] hdr_len;

  assign frame_last = mode_cept ? CEPT_LAST : DS1_LAST;
  assign hdr_len    = mode_cept ? CEPT_H : DS1_H;

  always_comb begin
    if (frame_start)
      cur_pos = '0;
    else if (last_pos >= frame_last)
      cur_pos = '0;
    else
      cur_pos = last_pos + 1'b1;
  end

  assign cmp_en        = bit_en && (cur_pos >= hdr_len);
  assign first_payload = bit_en && (cur_pos == hdr_len);

  always_ff @(posedge clk) begin
    if (!rst_n)
      last_pos <= '1;
    else if (bit_en)
      last_pos <= cur_pos;
  end

endmodule

// File: rtl/pattern_detector.sv
module pattern_detector
  import prbs_mon_pkg::*;
#(
  parameter int LEN       = 15,
  parameter int TAP       = 14,
  parameter int ZS_RUN    = 0,
  parameter int LOCK_RUN  = 256,
  parameter int ERR_LIMIT = 32,
  parameter int EW        = $clog2(ERR_LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en,
  input  logic          first_payload,
  input  logic          rx_bit,
  output logic          locked,
  output logic          mismatch,
  output logic [EW-1:0] err_count
);

  localparam int SW = $clog2(LEN + 1);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [SW-1:0] SEED_LAST = SW'(LEN - 1);
  localparam logic [RW-1:0] RUN_LAST  = RW'(LOCK_RUN - 1);
  localparam logic [EW-1:0] ERR_MAX   = EW'(ERR_LIMIT);

  det_state_e     state;
  logic [LEN-1:0] shreg;
  logic [SW-1:0]  seed_cnt;
  logic [RW-1:0]  run_cnt;
  logic [EW-1:0]  err_cnt;

  logic           raw_next;
  logic           zs_hit;
  logic           pred_bit;
  logic [LEN-1:0] seed_full;

  assign raw_next = lfsr_feedback(32'(shreg), TAP, LEN);

  generate
    if (ZS_RUN > 0) begin : g_zs
      assign zs_hit = zero_window(32'(shreg), ZS_RUN);
    end else begin : g_plain
      assign zs_hit = 1'b0;
    end
  endgenerate

  assign pred_bit  = raw_next | zs_hit;
  assign seed_full = {shreg[LEN-2:0], rx_bit};
  assign mismatch  = cmp_en && (state != DET_SEED) && (rx_bit != pred_bit);
  assign locked    = (state == DET_LOCK);
  assign err_count = err_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= DET_SEED;
      shreg    <= '0;
      seed_cnt <= '0;
      run_cnt  <= '0;
      err_cnt  <= '0;
    end else if (cmp_en) begin
      case (state)
        DET_SEED: begin
          shreg <= seed_full;
          if (seed_cnt == SEED_LAST) begin
            seed_cnt <= '0;
            run_cnt  <= '0;
            if (seed_full != '0)
              state <= DET_TRACK;
          end else begin
            seed_cnt <= seed_cnt + 1'b1;
          end
        end
        DET_TRACK: begin
          shreg <= {shreg[LEN-2:0], raw_next};
          if (mismatch) begin
            state    <= DET_SEED;
            seed_cnt <= '0;
          end else if (run_cnt == RUN_LAST) begin
            state   <= DET_LOCK;
            err_cnt <= '0;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
        DET_LOCK: begin
          shreg <= {shreg[LEN-2:0], raw_next};
          if (first_payload) begin
            err_cnt <= mismatch ? EW'(1) : '0;
          end else if (mismatch) begin
            if (err_cnt >= ERR_MAX) begin
              state    <= DET_SEED;
              seed_cnt <= '0;
              err_cnt  <= '0;
            end else begin
              err_cnt <= err_cnt + 1'b1;
            end
          end
        end
        default: begin
          state    <= DET_SEED;
          seed_cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/prbs_lock_monitor.sv
module prbs_lock_monitor #(
  parameter int DS1_LEN   = 193,
  parameter int DS1_HDR   = 1,
  parameter int CEPT_LEN  = 256,
  parameter int CEPT_HDR  = 8,
  parameter int LOCK_RUN  = 256,
  parameter int ERR_LIMIT = 32,
  parameter int ZS_RUN    = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic frame_start,
  input  logic mode_cept,
  output logic lock_p15,
  output logic lock_qrs
);

  localparam int EW = $clog2(ERR_LIMIT + 2);

  logic          cmp_en;
  logic          first_pl;
  logic          mis15;
  logic          mis20;
  logic [EW-1:0] err15;
  logic [EW-1:0] err20;

  frame_tracker #(
    .DS1_LEN (DS1_LEN),
    .DS1_HDR (DS1_HDR),
    .CEPT_LEN(CEPT_LEN),
    .CEPT_HDR(CEPT_HDR)
  ) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .frame_start  (frame_start),
    .mode_cept    (mode_cept),
    .cmp_en       (cmp_en),
    .first_payload(first_pl)
  );

  pattern_detector #(
    .LEN(15), .TAP(14), .ZS_RUN(0),
    .LOCK_RUN(LOCK_RUN), .ERR_LIMIT(ERR_LIMIT), .EW(EW)
  ) u_det15 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_en       (cmp_en),
    .first_payload(first_pl),
    .rx_bit       (rx_bit),
    .locked       (lock_p15),
    .mismatch     (mis15),
    .err_count    (err15)
  );

  pattern_detector #(
    .LEN(20), .TAP(17), .ZS_RUN(ZS_RUN),
    .LOCK_RUN(LOCK_RUN), .ERR_LIMIT(ERR_LIMIT), .EW(EW)
  ) u_det20 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_en       (cmp_en),
    .first_payload(first_pl),
    .rx_bit       (rx_bit),
    .locked       (lock_qrs),
    .mismatch     (mis20),
    .err_count    (err20)
  );

endmodule

// File: rtl/prbs_lock_monitor_chk.sv
module prbs_lock_monitor_chk #(
  parameter int ERR_LIMIT = 32,
  parameter int EW        = $clog2(ERR_LIMIT + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          cmp_en,
  input logic          first_pl,
  input logic          mis15,
  input logic          mis20,
  input logic [EW-1:0] err15,
  input logic [EW-1:0] err20,
  input logic          lock15,
  input logic          lock20
);

  assert_rise15_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock15) |-> $past(cmp_en && !mis15));

  assert_rise20_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock20) |-> $past(cmp_en && !mis20));

  assert_fall15_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock15) |-> $past(cmp_en && mis15));

  assert_fall20_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock20) |-> $past(cmp_en && mis20));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmp_en) |-> ($stable(lock15) && $stable(lock20)));

  assert_first_is_strobed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    first_pl |-> (bit_en && cmp_en));

  assert_err_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err15 <= EW'(ERR_LIMIT)) && (err20 <= EW'(ERR_LIMIT)));

endmodule

bind prbs_lock_monitor prbs_lock_monitor_chk #(.ERR_LIMIT(ERR_LIMIT), .EW(EW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_en  (bit_en),
  .cmp_en  (cmp_en),
  .first_pl(first_pl),
  .mis15   (mis15),
  .mis20   (mis20),
  .err15   (err15),
  .err20   (err20),
  .lock15  (lock_p15),
  .lock20  (lock_qrs)
);

// File: tb/test_prbs_lock_monitor.sv
`timescale 1ns/1ps
module test_prbs_lock_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic rx_bit = 1'b0;
  logic frame_start = 1'b0;
  logic mode_cept = 1'b0;
  logic lock_p15, lock_qrs;

  always #4 clk = ~clk;

  prbs_lock_monitor i_prbs_lock_monitor (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .mode_cept(mode_cept),
    .lock_p15(lock_p15), .lock_qrs(lock_qrs)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_last;
  int m_st[2];     // 0 seeding, 1 counting, 2 locked
  int m_seed[2];
  int m_run[2];
  int m_err[2];
  bit m_hist[2][20];

  task automatic push_hist(input int d, input bit v);
    for (int k = 19; k > 0; k--) m_hist[d][k] = m_hist[d][k-1];
    m_hist[d][0] = v;
  endtask

  task automatic model_step(input int d, input bit b, input bit first);
    int len, tap;
    bit raw, pred, allz, nz;
    len = (d == 0) ? 15 : 20;
    tap = (d == 0) ? 14 : 17;
    if (m_st[d] == 0) begin
      push_hist(d, b);
      m_seed[d]++;
      if (m_seed[d] == len) begin
        m_seed[d] = 0;
        nz = 0;
        for (int k = 0; k < len; k++) if (m_hist[d][k]) nz = 1;
        if (nz) begin m_st[d] = 1; m_run[d] = 0; end
      end
    end else begin
      raw = m_hist[d][tap-1] ^ m_hist[d][len-1];
      pred = raw;
      if (d == 1) begin
        allz = 1;
        for (int k = 0; k < 14; k++) if (m_hist[d][k]) allz = 0;
        if (allz) pred = 1;
      end
      push_hist(d, raw);
      if (m_st[d] == 1) begin
        if (b != pred) begin m_st[d] = 0; m_seed[d] = 0; end
        else begin
          m_run[d]++;
          if (m_run[d] == 256) begin m_st[d] = 2; m_err[d] = 0; end
        end
      end else begin
        if (first) m_err[d] = (b != pred) ? 1 : 0;
        else if (b != pred) begin
          if (m_err[d] >= 32) begin m_st[d] = 0; m_seed[d] = 0; m_err[d] = 0; end
          else m_err[d]++;
        end
      end
    end
  endtask

  always @(posedge clk) begin : model
    int pos, hdr, fl;
    if (!rst_n) begin
      m_last = 255;
      for (int d = 0; d < 2; d++) begin
        m_st[d] = 0; m_seed[d] = 0; m_run[d] = 0; m_err[d] = 0;
        for (int k = 0; k < 20; k++) m_hist[d][k] = 0;
      end
    end else if (bit_en) begin
      hdr = mode_cept ? 8 : 1;
      fl  = mode_cept ? 256 : 193;
      if (frame_start) pos = 0;
      else if (m_last >= fl - 1) pos = 0;
      else pos = m_last + 1;
      m_last = pos;
      if (pos >= hdr)
        for (int d = 0; d < 2; d++) model_step(d, rx_bit, pos == hdr);
    end
  end

  always @(negedge clk) begin
    check(lock_p15 == (m_st[0] == 2), "R6/R9/R10", "lock_p15 vs model", lock_p15, m_st[0] == 2);
    check(lock_qrs == (m_st[1] == 2), "R6/R9/R11", "lock_qrs vs model", lock_qrs, m_st[1] == 2);
  end

  // ---------------- pattern sources ----------------
  int pat = 0;              // 0 zeros, 1 pattern-15, 2 quasi-random
  logic [14:0] p15 = '1;
  logic [19:0] q20 = '1;
  int zrun = 0;

  function automatic bit src_next();
    bit nb, t;
    if (pat == 1) begin
      nb = p15[13] ^ p15[14];
      p15 = {p15[13:0], nb};
      return nb;
    end else if (pat == 2) begin
      nb = q20[16] ^ q20[19];
      t = (zrun >= 14) ? 1'b1 : nb;
      q20 = {q20[18:0], nb};
      zrun = nb ? 0 : zrun + 1;
      return t;
    end
    return 1'b0;
  endfunction

  int pl_sent = 0;
  int lock_at = 0;
  int garb = 7;

  task automatic send_bit(input bit b, input bit fs, input bit is_pl);
    bit_en = 1'b1; rx_bit = b; frame_start = fs;
    @(negedge clk);
    bit_en = 1'b0; frame_start = 1'b0;
    if (is_pl) begin
      pl_sent++;
      if (lock_at > 0 && pl_sent == lock_at - 1)
        check(lock_p15 == 1'b0, "R6/R7", "lock_p15 one bit before due", lock_p15, 0);
      if (lock_at > 0 && pl_sent == lock_at)
        check(lock_p15 == 1'b1, "R6/R7", "lock_p15 when due", lock_p15, 1);
    end
  endtask

  task automatic idle_cycle();
    bit_en = 1'b0;
    garb = garb * 5 + 3;
    rx_bit = garb[2];     // R4: toggles while not strobed
    @(negedge clk);
  endtask

  task automatic send_frame(input int err_from, input int nerr, input bit fs, input bit gaps);
    int fl, hdr, pi;
    bit b;
    fl  = mode_cept ? 256 : 193;
    hdr = mode_cept ? 8 : 1;
    pi = 0;
    for (int p = 0; p < fl; p++) begin
      if (p < hdr) begin
        send_bit((p % 3) == 0, fs && (p == 0), 1'b0);
      end else begin
        b = src_next();
        if (pi >= err_from && pi < err_from + nerr) b = ~b;
        pi++;
        send_bit(b, fs && (p == 0), 1'b1);
      end
      if (gaps && (p % 5 == 0)) idle_cycle();
    end
  endtask

  task automatic do_reset(input bit cept, input int new_pat);
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; frame_start = 1'b0;
    mode_cept = cept; pat = new_pat;
    p15 = '1; q20 = '1; zrun = 0;
    pl_sent = 0; lock_at = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1
    repeat (2) @(negedge clk);
    check(lock_p15 == 0 && lock_qrs == 0, "R1", "flags during reset", {lock_p15, lock_qrs}, 0);
    do_reset(1'b0, 1);
    check(lock_p15 == 0 && lock_qrs == 0, "R1", "flags after reset", {lock_p15, lock_qrs}, 0);

    // R2 R6 R10 R12: clean DS1, frame_start only on first frame
    lock_at = 271;
    send_frame(0, 0, 1'b1, 1'b0);
    send_frame(0, 0, 1'b0, 1'b0);
    lock_at = 0;
    check(lock_p15 == 1, "R2/R10", "lock_p15 after clean DS1", lock_p15, 1);
    check(lock_qrs == 0, "R12", "lock_qrs on 15-bit pattern", lock_qrs, 0);

    // R8: two frames with 32 errors each
    send_frame(0, 32, 1'b1, 1'b0);
    check(lock_p15 == 1, "R8", "lock after 32-error frame", lock_p15, 1);
    send_frame(150, 32, 1'b1, 1'b0);
    check(lock_p15 == 1, "R8", "lock after second 32-error frame", lock_p15, 1);

    // R9 then relock (R5)
    send_frame(10, 33, 1'b1, 1'b0);
    check(lock_p15 == 0, "R9", "lock after 33-error frame", lock_p15, 0);
    send_frame(0, 0, 1'b1, 1'b0);
    send_frame(0, 0, 1'b1, 1'b0);
    check(lock_p15 == 1, "R5", "relock after loss", lock_p15, 1);

    // R7: one mismatch at payload bit 101 during the run
    do_reset(1'b0, 1);
    lock_at = 372;
    send_frame(100, 1, 1'b1, 1'b0);
    send_frame(0, 0, 1'b1, 1'b0);
    lock_at = 0;
    check(lock_p15 == 1, "R7", "lock_p15 after restart", lock_p15, 1);

    // R3 R4 R11 R12: CEPT quasi-random with idle gaps
    do_reset(1'b1, 2);
    send_frame(0, 0, 1'b1, 1'b1);
    send_frame(0, 0, 1'b1, 1'b1);
    send_frame(0, 0, 1'b1, 1'b1);
    check(lock_qrs == 1, "R3/R11", "lock_qrs after clean CEPT", lock_qrs, 1);
    check(lock_p15 == 0, "R12", "lock_p15 on quasi-random", lock_p15, 0);
    repeat (20) idle_cycle();
    check(lock_qrs == 1, "R4", "lock_qrs after idle cycles", lock_qrs, 1);
    send_frame(100, 33, 1'b1, 1'b0);
    check(lock_qrs == 0, "R9", "lock_qrs after 33-error frame", lock_qrs, 0);

    // R5: all-zero payload
    do_reset(1'b0, 0);
    repeat (3) send_frame(0, 0, 1'b1, 1'b0);
    check(lock_p15 == 0, "R5", "lock_p15 on zero payload", lock_p15, 0);
    check(lock_qrs == 0, "R5", "lock_qrs on zero payload", lock_qrs, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule